// File: doc/BRIEF.md
# Serial Interrupt Agent

This block is the peripheral end of a single-wire, clock-synchronous interrupt bus. It takes sixteen local request lines and places each one in a fixed three-clock frame slot that follows a start pulse. The shared wire is modelled as three signals. One is the sampled line value. The other two are a drive value and a drive enable, which together stand in for an open-drain pin that can also be released. In its slot the agent pulls the line low for one clock when the request is active. It then drives the line high for one recovery clock and releases it.

The host ends every cycle with a stop pulse. The agent measures how long that pulse is and uses the length to set the mode of the next cycle. A short stop selects quiet mode. In quiet mode the agent may open a cycle itself when one of its requests has changed since it last reported it. A long stop selects continuous mode, in which only the host opens cycles. The third slot carries one of two sources, chosen by a select input: an active-low system-management request or interrupt 2. The first slot is never used.

Top module: `sirq_agent`

## Requirements
- R1: After reset the drive enable is low, the agent is idle and the mode is continuous.
- R2: The agent recognizes a start pulse only while idle, and only when the line was high and then stays low for 4 to 8 clocks in a row. Clock 0 is the first high clock after that low run. A low run of 3 clocks, or of 9 or more clocks, causes no frame activity.
- R3: The request for period p (p = 1..16) is bit p-1 of `irq_i`. When it is active (high), the agent drives the line low in clock 3p-1 and high in clock 3p. It releases the line in clock 3p+1. When the request is inactive, the line is released in all three clocks.
- R4: Period 1, which is clock 2 and bit 0 of `irq_i`, is never driven. Bit 0 never counts as a change in quiet mode.
- R5: With `smi_slot_i` = 1, period 3 (clock 8) reports `smi_n_i` = 0 as active and ignores `irq_i[2]`. With `smi_slot_i` = 0, period 3 reports `irq_i[2]` and ignores `smi_n_i`.
- R6: While a cycle is active, a low run of exactly 2 clocks followed by a high clock is a stop that selects quiet mode. A run of exactly 3 clocks is a stop that selects continuous mode. Either stop ends the cycle. One-clock lows inside data frames do not end the cycle.
- R7: In continuous mode the agent never drives the line while idle.
- R8: In quiet mode with a change pending, the agent drives the line low for exactly one clock and then releases it. The earliest clock for this is the second high clock after the stop's rising edge. It drives no further start until a new cycle is recognized.
- R9: A change is pending when any period's current value differs from the value the agent last reported in that period's sample clock. All reported values reset to inactive. When no change is pending, no start is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling and driving happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Active-high requests; bit n is carried in period n+1 |
| smi_n_i | input | 1 | Active-low system-management request |
| smi_slot_i | input | 1 | 1: period 3 carries `smi_n_i`; 0: period 3 carries `irq_i[2]` |
| sirq_i | input | 1 | Sampled level of the shared line |
| sirq_o | output | 1 | Level driven onto the line when enabled |
| sirq_oe_o | output | 1 | Drive enable; low releases the line |

## Verification
Two events can land on the same rising edge: the host's short stop is recognized, and the agent decides to open a new cycle. The bench changes a request after that request's slot has been reported, so a change is pending when the 2-clock stop ends. It then checks that the line is released in the first high clock, pulled low by the agent in the second high clock, and released again in the third. The host then stretches the start pulse, and the frame that follows must carry the new request values. A second run with only bit 0 changed, and a third after a 3-clock stop, must both leave the line untouched.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic {
        MODE_CONT  = 1'b0,
        MODE_QUIET = 1'b1
    } sirq_mode_e;

    localparam int unsigned STOP_QUIET_LEN = 2;
    localparam int unsigned STOP_CONT_LEN  = 3;

endpackage

// File: rtl/sirq_line_mon.sv
module sirq_line_mon #(
    parameter int unsigned START_MIN = 4,
    parameter int unsigned START_MAX = 8,
    parameter int unsigned RUNW      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic start_o,
    output logic stop_quiet_o,
    output logic stop_cont_o
);
    import sirq_pkg::*;

    logic [RUNW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (line_i) begin
            run_d = '0;
        end else if (!(&run_q)) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '1;
        end else begin
            run_q <= run_d;
        end
    end

    assign start_o      = line_i && (run_q >= RUNW'(START_MIN)) && (run_q <= RUNW'(START_MAX));
    assign stop_quiet_o = line_i && (run_q == RUNW'(STOP_QUIET_LEN));
    assign stop_cont_o  = line_i && (run_q == RUNW'(STOP_CONT_LEN));

endmodule

// File: rtl/sirq_slot_map.sv
module sirq_slot_map #(
    parameter int unsigned SLOTS    = 16,
    parameter int unsigned SHARED_K = 2
) (
    input  logic [SLOTS-1:0] irq_i,
    input  logic             smi_n_i,
    input  logic             smi_slot_i,
    output logic [SLOTS-1:0] req_o
);
    localparam logic USE_FIRST = 1'b0;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k == 0) begin : g_unused
            assign req_o[k] = irq_i[k] & USE_FIRST;
        end else if (k == SHARED_K) begin : g_shared
            assign req_o[k] = smi_slot_i ? !smi_n_i : irq_i[k];
        end else begin : g_plain
            assign req_o[k] = irq_i[k];
        end
    end

endmodule

// File: rtl/sirq_slot_dec.sv
module sirq_slot_dec #(
    parameter int unsigned SLOTS      = 16,
    parameter int unsigned FRAME_CLKS = 3,
    parameter int unsigned CNTW       = 6
) (
    input  logic [CNTW-1:0]  cnt_i,
    output logic [SLOTS-1:0] samp_o,
    output logic [SLOTS-1:0] rec_o
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_hit
        assign samp_o[k] = (cnt_i == CNTW'(FRAME_CLKS * (k + 1) - 1));
        assign rec_o[k]  = (cnt_i == CNTW'(FRAME_CLKS * (k + 1)));
    end

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent #(
    parameter int unsigned SLOTS      = 16,
    parameter int unsigned FRAME_CLKS = 3,
    parameter int unsigned START_MIN  = 4,
    parameter int unsigned START_MAX  = 8,
    parameter int unsigned SHARED_K   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] irq_i,
    input  logic             smi_n_i,
    input  logic             smi_slot_i,
    input  logic             sirq_i,
    output logic             sirq_o,
    output logic             sirq_oe_o
);
    import sirq_pkg::*;

    localparam int unsigned LAST_CLK = FRAME_CLKS * SLOTS + 1;
    localparam int unsigned CNTW     = $clog2(LAST_CLK + 2);
    localparam int unsigned RUNW     = $clog2(START_MAX + 2);

    typedef struct packed {
        logic             active;
        sirq_mode_e       mode;
        logic             started;
        logic [CNTW-1:0]  cnt;
        logic [SLOTS-1:0] rep;
        logic             oe;
        logic             o;
    } agent_st_t;

    agent_st_t st_d, st_q;

    logic             start_det, stop_quiet, stop_cont;
    logic [SLOTS-1:0] req;
    logic [SLOTS-1:0] samp_hit, rec_hit;
    logic [CNTW-1:0]  cnt_inc;
    logic             pending;

    sirq_line_mon #(
        .START_MIN (START_MIN),
        .START_MAX (START_MAX),
        .RUNW      (RUNW)
    ) u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (sirq_i),
        .start_o      (start_det),
        .stop_quiet_o (stop_quiet),
        .stop_cont_o  (stop_cont)
    );

    sirq_slot_map #(
        .SLOTS    (SLOTS),
        .SHARED_K (SHARED_K)
    ) u_map (
        .irq_i      (irq_i),
        .smi_n_i    (smi_n_i),
        .smi_slot_i (smi_slot_i),
        .req_o      (req)
    );

    assign cnt_inc = (&st_q.cnt) ? st_q.cnt : st_q.cnt + 1'b1;

    sirq_slot_dec #(
        .SLOTS      (SLOTS),
        .FRAME_CLKS (FRAME_CLKS),
        .CNTW       (CNTW)
    ) u_dec (
        .cnt_i  (cnt_inc),
        .samp_o (samp_hit),
        .rec_o  (rec_hit)
    );

    assign pending = |(req ^ st_q.rep);

    always_comb begin
        st_d    = st_q;
        st_d.oe = 1'b0;
        st_d.o  = 1'b1;

        if (st_q.active) begin
            if (stop_quiet || stop_cont) begin
                st_d.active  = 1'b0;
                st_d.mode    = stop_quiet ? MODE_QUIET : MODE_CONT;
                st_d.started = 1'b0;
            end else begin
                st_d.cnt = cnt_inc;
                for (int k = 0; k < SLOTS; k++) begin
                    if (samp_hit[k]) begin
                        st_d.rep[k] = req[k];
                        if (req[k]) begin
                            st_d.oe = 1'b1;
                            st_d.o  = 1'b0;
                        end
                    end
                    if (rec_hit[k] && st_q.oe && !st_q.o) begin
                        st_d.oe = 1'b1;
                        st_d.o  = 1'b1;
                    end
                end
            end
        end else if (start_det) begin
            st_d.active  = 1'b1;
            st_d.cnt     = CNTW'(1);
            st_d.started = 1'b0;
        end

        if (!st_d.active && (st_d.mode == MODE_QUIET) && pending &&
            sirq_i && !st_d.started && !start_det) begin
            st_d.oe      = 1'b1;
            st_d.o       = 1'b0;
            st_d.started = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active  <= 1'b0;
            st_q.mode    <= MODE_CONT;
            st_q.started <= 1'b0;
            st_q.cnt     <= '0;
            st_q.rep     <= '0;
            st_q.oe      <= 1'b0;
            st_q.o       <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sirq_o    = st_q.o;
    assign sirq_oe_o = st_q.oe;

    logic            chk_active;
    logic            chk_quiet;
    logic [CNTW-1:0] chk_cnt;
    assign chk_active = st_q.active;
    assign chk_quiet  = (st_q.mode == MODE_QUIET);
    assign chk_cnt    = st_q.cnt;

endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk #(
    parameter int unsigned CNTW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            oe,
    input logic            o,
    input logic            active,
    input logic            quiet,
    input logic [CNTW-1:0] cnt
);
    a_r3_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (active && oe && !o) |=> (oe && o));

    a_r3_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && o) |=> !oe);

    a_r4_first_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt == CNTW'(2)) |-> !oe);

    a_r7_cont_idle_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !quiet) |-> !oe);

    a_r8_start_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && oe && !o) |=> !oe);

endmodule

bind sirq_agent sirq_agent_chk #(.CNTW(CNTW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe     (sirq_oe_o),
    .o      (sirq_o),
    .active (chk_active),
    .quiet  (chk_quiet),
    .cnt    (chk_cnt)
);

// File: tb/sirq_agent_tb.sv
module sirq_agent_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        smi_n = 1'b1;
    logic        smi_slot = 1'b0;
    logic        host_low = 1'b0;
    logic        sirq_o, sirq_oe;
    logic        line;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #2 clk = ~clk;

    assign line = !host_low & (sirq_oe ? sirq_o : 1'b1);

    sirq_agent u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_i      (irq),
        .smi_n_i    (smi_n),
        .smi_slot_i (smi_slot),
        .sirq_i     (line),
        .sirq_o     (sirq_o),
        .sirq_oe_o  (sirq_oe)
    );

    task automatic chk(input string tag, input logic eoe, input logic eo);
        n_tests++;
        if (sirq_oe !== eoe || (eoe && sirq_o !== eo)) begin
            n_fail++;
            $display("FAIL %s t=%0t oe/o actual %b/%b expected %b/%b",
                     tag, $time, sirq_oe, sirq_o, eoe, eo);
        end
    endtask

    task automatic step(input logic low);
        @(negedge clk);
        host_low = low;
    endtask

    function automatic logic [15:0] exp_vec();
        logic [15:0] v;
        v    = irq;
        v[0] = 1'b0;
        v[2] = smi_slot ? !smi_n : irq[2];
        return v;
    endfunction

    task automatic host_start(input int len);
        step(1'b0);
        for (int i = 0; i < len; i++) step(1'b1);
    endtask

    task automatic host_stop(input int len);
        for (int i = 0; i < len; i++) step(1'b1);
    endtask

    task automatic frame(input string tag, input logic [15:0] ev);
        for (int c = 0; c < 50; c++) begin
            logic eoe, eo;
            step(1'b0);
            eoe = 1'b0;
            eo  = 1'b1;
            for (int p = 1; p <= 16; p++) begin
                if (ev[p-1] && c == 3*p-1) begin eoe = 1'b1; eo = 1'b0; end
                if (ev[p-1] && c == 3*p)   begin eoe = 1'b1; eo = 1'b1; end
            end
            chk(tag, eoe, eo);
        end
    endtask

    task automatic quiet_line(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0);
            chk(tag, 1'b0, 1'b1);
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        quiet_line("R1 reset released", 4);
    endtask

    task automatic t_slots();
        irq = 16'b1001_0110_1100_1011;
        host_start(4);
        frame("R3 slot timing", exp_vec());
        host_stop(3);
        irq = 16'h0001;
        host_start(5);
        frame("R4 period1 unused", 16'h0000);
        host_stop(3);
    endtask

    task automatic t_shared();
        smi_slot = 1'b1; smi_n = 1'b0; irq = 16'h0000;
        host_start(8);
        frame("R5 smi selected active", 16'h0004);
        host_stop(3);
        smi_n = 1'b1; irq = 16'h0004;
        host_start(6);
        frame("R5 irq2 ignored", 16'h0000);
        host_stop(3);
        smi_slot = 1'b0; smi_n = 1'b0; irq = 16'h0000;
        host_start(4);
        frame("R5 smi ignored", 16'h0000);
        host_stop(3);
        smi_n = 1'b1; irq = 16'h0004;
        host_start(4);
        frame("R5 irq2 selected", 16'h0004);
        host_stop(3);
    endtask

    task automatic t_bad_start();
        irq = 16'hFFFE;
        host_start(3);
        quiet_line("R2 short low run", 50);
        host_start(9);
        quiet_line("R2 long low run", 50);
        host_start(4);
        frame("R2 valid start", exp_vec());
        host_stop(3);
    endtask

    task automatic t_modes();
        irq = 16'h00F0;
        quiet_line("R7 continuous no start", 20);
        host_start(4);
        frame("R6 frame before short stop", exp_vec());
        irq = 16'h0F00;
        host_stop(2);
        step(1'b0);
        chk("R8 first high clock released", 1'b0, 1'b1);
        step(1'b0);
        chk("R8 agent start low", 1'b1, 1'b0);
        step(1'b1);
        chk("R8 start lasts one clock", 1'b0, 1'b1);
        step(1'b1);
        step(1'b1);
        frame("R6 quiet cycle reports change", exp_vec());
        irq = 16'h0F01;
        host_stop(2);
        quiet_line("R9 no change no start", 20);
        host_start(4);
        frame("R9 host start in quiet", exp_vec());
        irq = 16'h0003;
        host_stop(3);
        quiet_line("R7 long stop blocks start", 20);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_slots();
        t_shared();
        t_bad_start();
        t_modes();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule